// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Sequencer

This block sits between a processor core and a 16-bit external bus. It takes one read or write request at a time. Each request carries a 24-bit byte address, a byte-or-word size flag, a memory-or-I/O flag and write data. The block turns the request into one or two external bus cycles. Every bus cycle has an address phase of one clock, followed by a command phase in which the active-low read or write strobe is driven. The command phase is stretched one clock at a time for as long as the slave holds the ready input low.

Byte data is steered onto the low or the high half of the data bus according to address bit 0. An active-low high-byte enable marks cycles that use the upper lane. A word at an odd memory address cannot go out in one cycle, so the block issues two byte cycles and rebuilds the 16-bit result before it reports completion. A word I/O access to an odd port is refused without any bus activity. Completion is a one-clock pulse that carries the assembled read data and an error flag.

Top module: `bus_lane_seq`

## Requirements
- R1: After reset, both strobes are high (inactive), `done` is low and `req_ready` is high.
- R2: A byte access to an even address gives `bus_bhe_n`=1 and uses data bits 7..0. A byte access to an odd address gives `bus_bhe_n`=0 and uses bits 15..8. The byte read back is returned in `done_rdata[7:0]` with the upper byte zero.
- R3: A word access at an even address completes in a single bus cycle with `bus_bhe_n`=0. Bits 7..0 carry the byte at that address, and bits 15..8 carry the byte at address+1.
- R4: A word memory access at an odd address A issues two bus cycles. The first goes to A on the high lane with `bus_bhe_n`=0 and carries the low byte. The second goes to A+1 (modulo 2^24) on the low lane with `bus_bhe_n`=1 and carries the high byte. The read result is {byte(A+1), byte(A)}.
- R5: While `bus_ready` is low at the end of a command clock, the strobe stays asserted for one more clock. With W not-ready samples, each command phase lasts W+1 clocks.
- R6: Each bus cycle is one address clock followed by the command phase. `done` rises P*(W+2)+1 falling edges after the request is taken, where P is the number of bus cycles.
- R7: `bus_io` is 0 during memory cycles and 1 during I/O cycles.
- R8: A word I/O request at an odd port address produces no bus cycle. It completes on the next clock with `done_err`=1. All other requests complete with `done_err`=0.
- R9: The read and write strobes are never low together. `bus_addr` and `bus_bhe_n` hold steady from the address clock to the end of the command phase.
- R10: Reads assert only `bus_rd_n` and writes assert only `bus_wr_n`. `done` is a single-clock pulse, and `req_ready` is low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 24 | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte accesses use bits 7..0) |
| done | output | 1 | One-clock completion pulse |
| done_err | output | 1 | Request refused (odd word I/O) |
| done_rdata | output | 16 | Assembled read data |
| bus_addr | output | 24 | Bus address |
| bus_io | output | 1 | Space select, high for I/O |
| bus_bhe_n | output | 1 | High-byte lane enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Write data to bus |
| bus_dout_en | output | 1 | Write data valid on `bus_dout` |
| bus_din | input | 16 | Read data from bus |
| bus_ready | input | 1 | Slave ready, sampled at end of each command clock |

## Verification
The bench builds the block with its default widths: a 24-bit address and a 16-bit data bus. With these widths, a split word at the very top of the address space wraps its second cycle to address zero, and a directed case covers this. The bus model holds ready low for 0 to 3 command clocks per cycle. This covers zero-wait timing as well as stretched command phases in both halves of a split access. Random requests mix every combination of size, space, direction and address parity.

// File: rtl/bls_pkg.sv
package bls_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2
    } phase_t;
endpackage

// File: rtl/bls_lane_plan.sv
// Works out address, high-lane enable and write-lane data for one bus cycle.
module bls_lane_plan #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              word,
    input  logic              second,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              bhe_n,
    output logic              split,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF = DATA_W / 2;
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [HALF-1:0] lane_byte;

    always_comb begin
        split     = word && base_addr[0];
        cyc_addr  = second ? (base_addr + ONE) : base_addr;
        bhe_n     = second ? 1'b1 : !(word || base_addr[0]);
        lane_byte = second ? wdata[DATA_W-1:HALF] : wdata[HALF-1:0];
        if (word && !base_addr[0])
            dout = wdata;
        else
            dout = {lane_byte, lane_byte};
    end
endmodule

// File: rtl/bls_rd_merge.sv
// Picks the active read lane and places it in the assembled result.
module bls_rd_merge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   din,
    input  logic                lane_hi,
    input  logic                full_word,
    input  logic                second,
    input  logic [DATA_W/2-1:0] low_acc,
    output logic [DATA_W-1:0]   merged
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] lane;

    always_comb begin
        lane = lane_hi ? din[DATA_W-1:HALF] : din[HALF-1:0];
        if (full_word)
            merged = din;
        else if (second)
            merged = {lane, low_acc};
        else
            merged = {{HALF{1'b0}}, lane};
    end
endmodule

// File: rtl/bus_lane_seq.sv
module bus_lane_seq #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_io,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] done_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_io,
    output logic              bus_bhe_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready
);
    import bls_pkg::*;

    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        phase_t            ph;
        logic              second;
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              io;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic              split;
    logic [ADDR_W-1:0] cyc_addr;
    logic              cyc_bhe_n;
    logic [DATA_W-1:0] cyc_dout;
    logic [DATA_W-1:0] merged;

    bls_lane_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
        .base_addr (st_q.addr),
        .word      (st_q.word),
        .second    (st_q.second),
        .wdata     (st_q.wdata),
        .cyc_addr  (cyc_addr),
        .bhe_n     (cyc_bhe_n),
        .split     (split),
        .dout      (cyc_dout)
    );

    bls_rd_merge #(.DATA_W(DATA_W)) u_merge (
        .din       (bus_din),
        .lane_hi   (cyc_addr[0]),
        .full_word (st_q.word && !st_q.addr[0]),
        .second    (st_q.second),
        .low_acc   (st_q.rdata[HALF-1:0]),
        .merged    (merged)
    );

    assign req_ready = (st_q.ph == PH_IDLE) && !st_q.done;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid && req_ready) begin
                    st_d.addr   = req_addr;
                    st_d.word   = req_word;
                    st_d.io     = req_io;
                    st_d.wr     = req_write;
                    st_d.wdata  = req_wdata;
                    st_d.second = 1'b0;
                    st_d.rdata  = '0;
                    if (req_io && req_word && req_addr[0]) begin
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else begin
                        st_d.ph = PH_ADDR;
                    end
                end
            end
            PH_ADDR: st_d.ph = PH_CMD;
            PH_CMD: begin
                if (bus_ready) begin
                    st_d.rdata = merged;
                    if (split && !st_q.second) begin
                        st_d.second = 1'b1;
                        st_d.ph     = PH_ADDR;
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done        = st_q.done;
    assign done_err    = st_q.err;
    assign done_rdata  = st_q.rdata;
    assign bus_addr    = cyc_addr;
    assign bus_bhe_n   = cyc_bhe_n;
    assign bus_io      = st_q.io;
    assign bus_rd_n    = !((st_q.ph == PH_CMD) && !st_q.wr);
    assign bus_wr_n    = !((st_q.ph == PH_CMD) && st_q.wr);
    assign bus_dout    = cyc_dout;
    assign bus_dout_en = (st_q.ph != PH_IDLE) && st_q.wr;

    logic strobe_on;
    assign strobe_on = !bus_rd_n || !bus_wr_n;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ADDR) |=> ($stable(bus_addr) && $stable(bus_bhe_n) && strobe_on));

    // R5
    wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && !bus_ready) |=> (strobe_on && $stable(bus_addr) && $stable(bus_rd_n)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    odd_io_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_io && req_word && req_addr[0]) |=> (done && done_err && !strobe_on));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |-> !req_ready);
endmodule

// File: tb/bus_lane_seq_bench.sv
module bus_lane_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_io = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        done, done_err;
    logic [15:0] done_rdata;
    logic [23:0] bus_addr;
    logic        bus_io, bus_bhe_n, bus_rd_n, bus_wr_n, bus_dout_en;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    bus_lane_seq u_bus_lane_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_word(req_word), .req_io(req_io), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .bus_addr(bus_addr), .bus_io(bus_io), .bus_bhe_n(bus_bhe_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ready(bus_ready)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    // bus monitor and slave model
    int          waits_cur = 0;
    int          mon_n = 0;
    logic [23:0] mon_addr [4];
    logic        mon_bhe [4];
    logic        mon_io [4];
    logic        mon_wr [4];
    logic        mon_both [4];
    logic [15:0] mon_dout [4];
    int          mon_len [4];
    logic        mon_unstable = 1'b0;
    logic        prev_on = 1'b0;

    always @(negedge clk) begin
        bus_din = {mem_byte(bus_addr | 24'h1), mem_byte(bus_addr & ~24'h1)};
        if (!bus_rd_n || !bus_wr_n) begin
            if (!prev_on) begin
                if (mon_n < 4) begin
                    mon_addr[mon_n] = bus_addr;
                    mon_bhe[mon_n]  = bus_bhe_n;
                    mon_io[mon_n]   = bus_io;
                    mon_wr[mon_n]   = !bus_wr_n;
                    mon_both[mon_n] = !bus_wr_n && !bus_rd_n;
                    mon_dout[mon_n] = bus_dout;
                    mon_len[mon_n]  = 1;
                end
                mon_n = mon_n + 1;
            end else if (mon_n >= 1 && mon_n <= 4) begin
                mon_len[mon_n-1] = mon_len[mon_n-1] + 1;
                if (bus_addr != mon_addr[mon_n-1] || bus_bhe_n != mon_bhe[mon_n-1])
                    mon_unstable = 1'b1;
            end
            bus_ready = (mon_n >= 1 && mon_n <= 4) ? (mon_len[mon_n-1] > waits_cur) : 1'b1;
            prev_on = 1'b1;
        end else begin
            bus_ready = 1'b0;
            prev_on = 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] a, input logic word, input logic io,
                       input logic wr, input logic [15:0] wd, input int w);
        int          parts;
        int          lat;
        logic        refuse;
        logic [23:0] ca;
        logic        exp_bhe;
        logic [7:0]  lane;
        logic [7:0]  exp_b;
        logic [15:0] exp_rd;
        while (!req_ready) @(negedge clk);
        refuse = io && word && a[0];
        parts  = refuse ? 0 : ((word && a[0]) ? 2 : 1);
        req_addr = a; req_word = word; req_io = io; req_write = wr; req_wdata = wd;
        waits_cur = w; mon_n = 0; mon_unstable = 1'b0;
        req_valid = 1'b1;
        lat = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (i == 0) chk(!req_ready, "R10 busy", 32'(req_ready), 0);
            if (done) break;
        end
        // R6 timing, R5 waits
        chk(lat == parts * (w + 2) + 1, "R6 latency", lat, parts * (w + 2) + 1);
        chk(mon_n == parts, "R4 cycle count", mon_n, parts);
        // R8 refusal flag
        chk(done_err == refuse, "R8 err", 32'(done_err), 32'(refuse));
        chk(!mon_unstable, "R9 addr stable", 32'(mon_unstable), 0);
        for (int k = 0; k < parts && k < mon_n && k < 4; k++) begin
            ca = (k == 0) ? a : a + 24'h1;
            exp_bhe = (k == 1) ? 1'b1 : !(word || a[0]);
            chk(mon_addr[k] == ca, "R4 cycle address", mon_addr[k], ca);
            chk(mon_bhe[k] == exp_bhe, "R2 bhe", 32'(mon_bhe[k]), 32'(exp_bhe));
            chk(mon_io[k] == io, "R7 space", 32'(mon_io[k]), 32'(io));
            chk(mon_wr[k] == wr && !mon_both[k], "R10 strobe dir", 32'(mon_wr[k]), 32'(wr));
            chk(mon_len[k] == w + 1, "R5 command length", mon_len[k], w + 1);
            if (wr) begin
                if (word && !a[0]) begin
                    chk(mon_dout[k] == wd, "R3 word lanes", mon_dout[k], wd);
                end else begin
                    exp_b = (k == 1) ? wd[15:8] : wd[7:0];
                    lane  = ca[0] ? mon_dout[k][15:8] : mon_dout[k][7:0];
                    chk(lane == exp_b, "R2 write lane", lane, exp_b);
                end
            end
        end
        if (!wr && !refuse) begin
            exp_rd = word ? {mem_byte(a + 24'h1), mem_byte(a)} : {8'h00, mem_byte(a)};
            chk(done_rdata == exp_rd, word ? "R4 read word" : "R2 read byte", done_rdata, exp_rd);
        end
        @(negedge clk);
        chk(!done, "R10 done pulse", 32'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_rd_n && bus_wr_n, "R1 strobes idle", {bus_rd_n, bus_wr_n}, 3);
        chk(!done && req_ready, "R1 handshake idle", {done, req_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);

        run(24'h000100, 1'b0, 1'b0, 1'b0, 16'h0000, 0); // R2 byte even read
        run(24'h000101, 1'b0, 1'b0, 1'b0, 16'h0000, 0); // R2 byte odd read
        run(24'h000103, 1'b0, 1'b0, 1'b1, 16'h00A5, 1); // R2 byte odd write
        run(24'h002000, 1'b1, 1'b0, 1'b0, 16'h0000, 0); // R3 even word
        run(24'h002002, 1'b1, 1'b0, 1'b1, 16'hBEEF, 2); // R3 even word write
        run(24'h003005, 1'b1, 1'b0, 1'b0, 16'h0000, 0); // R4 split read
        run(24'h003007, 1'b1, 1'b0, 1'b1, 16'h1234, 3); // R4 split write with waits
        run(24'hFFFFFF, 1'b1, 1'b0, 1'b0, 16'h0000, 1); // R4 wrap to zero
        run(24'h000061, 1'b0, 1'b1, 1'b0, 16'h0000, 0); // R7 io byte odd
        run(24'h000060, 1'b1, 1'b1, 1'b1, 16'h5A5A, 2); // R7 io word even
        run(24'h000063, 1'b1, 1'b1, 1'b0, 16'h0000, 0); // R8 refused
        run(24'h000065, 1'b1, 1'b1, 1'b1, 16'hFFFF, 0); // R8 refused write

        for (int n = 0; n < 300; n++) begin
            run(24'($urandom()), 1'($urandom()), 1'($urandom_range(0, 3) == 0),
                1'($urandom()), 16'($urandom()), int'($urandom_range(0, 3)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule